// File: doc/BRIEF.md
# Tach Period Averaging Sequencer

This block sits next to a bank of fan tachometer capture timers. Each capture timer counts down from all-ones and reports either a capture event, carrying the counter value latched on a tach edge, or a timeout event when the fan is too slow or missing. For every channel the block runs a small sample state machine. It throws away the first capture after a restart, adds up the elapsed counts (all-ones minus the captured value) of the next two captures, and publishes half of that sum as the average count per tach pulse. It then stops the channel. A timeout stops the channel and forces its result to zero.

A built-in interval timer restarts capture in a fixed rotating order. Modules are split into four groups, where module m belongs to group m mod 4. On each tick one group is serviced, so every present channel is re-armed once per four ticks. A restart pulses the channel's reload output, which tells the capture timer to clear its flags and reload its counter, and raises the channel's run enable. Channels marked absent are never armed.

The channel states are OFF (8'hFF), INIT (8'h00), FIRST (8'h01) and ENOUGH (8'h02). The transitions are RESTART (any state to INIT), DROP (INIT to FIRST), ACCUMULATE (FIRST to ENOUGH), FINISH (ENOUGH to INIT with a stop) and TIMEOUT (state kept, stop and zero result).

Top module: `tach_avg_seq`

## Requirements
- R1: After reset every channel is in OFF, and run_en, reload and every avg_count field read zero.
- R2: A tick fires every TICK_CYCLES clock cycles. Ticks service groups 0, 1, 2, 3 and then repeat. Group p holds the modules m with m mod 4 == p, and module m owns channels 2m and 2m+1. The reload bits of the serviced present channels are high for exactly one cycle, starting in the cycle after the tick edge, and consecutive reload pulses are TICK_CYCLES cycles apart.
- R3: RESTART of a present channel puts it in INIT, sets its run_en bit and drops any sample collection in progress, while its avg_count keeps its previous value.
- R4: A channel whose chan_present bit is 0 is never restarted. Its reload and run_en bits stay 0 and it stays in OFF.
- R5: A capture on an armed channel in INIT is discarded. The accumulator is cleared, the state becomes FIRST and run_en stays 1.
- R6: A capture on an armed channel in FIRST adds 16'hFFFF minus the captured value to a 17-bit accumulator and moves to ENOUGH, with no change to avg_count.
- R7: A capture on an armed channel in ENOUGH adds its elapsed count, writes the 17-bit sum shifted right by one (truncated) to avg_count, returns to INIT and clears run_en. Both changes are visible in the cycle after the capture.
- R8: A timeout on an armed channel clears run_en and sets avg_count to zero in the next cycle. The sample state is unchanged.
- R9: When a timeout and a capture reach an armed channel in the same cycle, the timeout takes effect and the capture is dropped.
- R10: When a restart and a capture reach a channel in the same cycle, the restart takes effect and the capture is dropped.
- R11: Captures and timeouts on a channel whose run_en is 0 are ignored, and its avg_count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_present | input | NCH | Channel is fitted and may be armed |
| cap_valid | input | NCH | Capture event per channel |
| cap_value | input | NCH*CNT_W | Captured counter value, channel c at bits [c*CNT_W +: CNT_W] |
| tmo_valid | input | NCH | Timeout event per channel |
| run_en | output | NCH | Capture clock and event enable per channel |
| reload | output | NCH | One-cycle request to clear flags and reload the counter |
| avg_count | output | NCH*CNT_W | Averaged count per pulse, channel c at bits [c*CNT_W +: CNT_W] |

## Verification
Two pairs of functions can land on the same channel in the same cycle: a timeout with a capture, and a scheduled restart with a capture. The timeout case is provoked by asserting both events together on an armed channel in FIRST. It is judged by run_en falling and avg_count reading zero, because a winning capture would have left the channel running. The restart case is provoked by timing a capture with a large elapsed count onto the exact tick edge, counted from the previous reload pulse, while the channel sits in ENOUGH. It is judged by run_en staying high, avg_count staying at its old value, and the next three captures producing a fresh average that excludes the colliding sample.

// File: rtl/tach_avg_pkg.sv
package tach_avg_pkg;

    typedef enum logic [7:0] {
        ST_INIT   = 8'h00,
        ST_FIRST  = 8'h01,
        ST_ENOUGH = 8'h02,
        ST_OFF    = 8'hFF
    } tach_st_e;

endpackage

// File: rtl/tach_tick_sched.sv
module tach_tick_sched #(
    parameter int TICK_CYCLES = 20_000_000,
    parameter int NUM_MOD     = 8,
    parameter int CH_PER_MOD  = 2,
    parameter int GROUPS      = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    output logic [NUM_MOD*CH_PER_MOD-1:0]  svc_o
);
    localparam int NCH = NUM_MOD * CH_PER_MOD;
    localparam int CW  = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
    localparam int PW  = (GROUPS > 1) ? $clog2(GROUPS) : 1;

    logic [CW-1:0] cnt_q;
    logic [PW-1:0] phase_q;
    logic          tick;

    assign tick = (cnt_q == CW'(TICK_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= '0;
        end else if (tick) begin
            cnt_q   <= '0;
            phase_q <= (phase_q == PW'(GROUPS - 1)) ? '0 : phase_q + 1'b1;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // each channel is serviced when the rotating phase reaches its module group
    for (genvar c = 0; c < NCH; c++) begin : g_svc
        localparam int GRP = (c / CH_PER_MOD) % GROUPS;
        assign svc_o[c] = tick && (phase_q == PW'(GRP));
    end

endmodule

// File: rtl/tach_chan_fsm.sv
module tach_chan_fsm
    import tach_avg_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          present_i,
    input  logic          svc_i,
    input  logic          cap_i,
    input  logic [CW-1:0] cap_val_i,
    input  logic          tmo_i,
    output tach_st_e      st_o,
    output logic          run_o,
    output logic          reload_o,
    output logic [CW-1:0] avg_o
);
    tach_st_e      st_q, st_d;
    logic [CW:0]   acc_q;
    logic [CW-1:0] delta;
    logic [CW:0]   sum;
    logic          do_restart, do_tmo, do_cap;

    assign delta      = {CW{1'b1}} - cap_val_i;
    assign sum        = acc_q + {1'b0, delta};
    assign do_restart = svc_i && present_i;
    assign do_tmo     = !do_restart && run_o && tmo_i;
    assign do_cap     = !do_restart && run_o && !tmo_i && cap_i;

    always_comb begin
        st_d = st_q;
        if (do_restart) begin
            st_d = ST_INIT;
        end else if (do_cap) begin
            unique case (st_q)
                ST_INIT:   st_d = ST_FIRST;
                ST_FIRST:  st_d = ST_ENOUGH;
                ST_ENOUGH: st_d = ST_INIT;
                ST_OFF:    st_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            run_o    <= 1'b0;
            reload_o <= 1'b0;
            avg_o    <= '0;
        end else begin
            reload_o <= 1'b0;
            if (do_restart) begin
                run_o    <= 1'b1;
                reload_o <= 1'b1;
            end else if (do_tmo) begin
                run_o <= 1'b0;
                avg_o <= '0;
            end else if (do_cap) begin
                unique case (st_q)
                    ST_INIT:   acc_q <= '0;
                    ST_FIRST:  acc_q <= sum;
                    ST_ENOUGH: begin
                        acc_q <= sum;
                        avg_o <= sum[CW:1];
                        run_o <= 1'b0;
                    end
                    ST_OFF:    acc_q <= acc_q;
                endcase
            end
        end
    end

    assign st_o = st_q;

endmodule

// File: rtl/tach_avg_seq.sv
module tach_avg_seq
    import tach_avg_pkg::*;
#(
    parameter int NUM_MOD     = 8,
    parameter int CH_PER_MOD  = 2,
    parameter int GROUPS      = 4,
    parameter int CNT_W       = 16,
    parameter int TICK_CYCLES = 20_000_000
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NUM_MOD*CH_PER_MOD-1:0]         chan_present,
    input  logic [NUM_MOD*CH_PER_MOD-1:0]         cap_valid,
    input  logic [NUM_MOD*CH_PER_MOD*CNT_W-1:0]   cap_value,
    input  logic [NUM_MOD*CH_PER_MOD-1:0]         tmo_valid,
    output logic [NUM_MOD*CH_PER_MOD-1:0]         run_en,
    output logic [NUM_MOD*CH_PER_MOD-1:0]         reload,
    output logic [NUM_MOD*CH_PER_MOD*CNT_W-1:0]   avg_count
);
    localparam int NCH = NUM_MOD * CH_PER_MOD;

    logic [NCH-1:0]      svc_mask;
    logic [NCH-1:0][7:0] chan_st;

    tach_tick_sched #(
        .TICK_CYCLES (TICK_CYCLES),
        .NUM_MOD     (NUM_MOD),
        .CH_PER_MOD  (CH_PER_MOD),
        .GROUPS      (GROUPS)
    ) u_sched (
        .clk   (clk),
        .rst_n (rst_n),
        .svc_o (svc_mask)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        tach_st_e st_w;

        tach_chan_fsm #(.CW(CNT_W)) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .present_i (chan_present[c]),
            .svc_i     (svc_mask[c]),
            .cap_i     (cap_valid[c]),
            .cap_val_i (cap_value[c*CNT_W +: CNT_W]),
            .tmo_i     (tmo_valid[c]),
            .st_o      (st_w),
            .run_o     (run_en[c]),
            .reload_o  (reload[c]),
            .avg_o     (avg_count[c*CNT_W +: CNT_W])
        );

        assign chan_st[c] = st_w;
    end

endmodule

// File: rtl/tach_avg_chk.sv
module tach_avg_chk
    import tach_avg_pkg::*;
#(
    parameter int NCH = 16,
    parameter int CW  = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NCH-1:0]       present,
    input logic [NCH-1:0]       svc,
    input logic [NCH-1:0]       cap_valid,
    input logic [NCH-1:0]       tmo_valid,
    input logic [NCH-1:0]       run_en,
    input logic [NCH-1:0]       reload,
    input logic [NCH*CW-1:0]    avg_count,
    input logic [NCH-1:0][7:0]  chan_st
);
    for (genvar i = 0; i < NCH; i++) begin : g_prop
        logic quiet_cap;
        assign quiet_cap = run_en[i] && cap_valid[i] && !tmo_valid[i] && !svc[i];

        p_reload_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
            reload[i] |=> !reload[i]);

        p_restart_arms_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (svc[i] && present[i]) |=> (run_en[i] && reload[i] && chan_st[i] == 8'h00
                                        && $stable(avg_count[i*CW +: CW])));

        p_absent_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (svc[i] && !present[i]) |=> !reload[i]);

        p_off_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_st[i] == 8'hFF) |-> !run_en[i]);

        p_first_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (quiet_cap && chan_st[i] == 8'h00) |=> (chan_st[i] == 8'h01 && run_en[i]
                                                   && $stable(avg_count[i*CW +: CW])));

        p_second_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (quiet_cap && chan_st[i] == 8'h01) |=> (chan_st[i] == 8'h02 && run_en[i]
                                                   && $stable(avg_count[i*CW +: CW])));

        p_final_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (quiet_cap && chan_st[i] == 8'h02) |=> (chan_st[i] == 8'h00 && !run_en[i]));

        p_tmo_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (run_en[i] && tmo_valid[i] && !svc[i]) |=> (!run_en[i] && avg_count[i*CW +: CW] == '0));

        p_tmo_over_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (run_en[i] && tmo_valid[i] && cap_valid[i] && !svc[i]) |=> (chan_st[i] == $past(chan_st[i])));

        p_restart_over_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (svc[i] && present[i] && cap_valid[i]) |=> (chan_st[i] == 8'h00 && run_en[i]));

        p_unarmed_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !run_en[i] |=> $stable(avg_count[i*CW +: CW]));
    end

endmodule

bind tach_avg_seq tach_avg_chk #(.NCH(NCH), .CW(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .present   (chan_present),
    .svc       (svc_mask),
    .cap_valid (cap_valid),
    .tmo_valid (tmo_valid),
    .run_en    (run_en),
    .reload    (reload),
    .avg_count (avg_count),
    .chan_st   (chan_st)
);

// File: tb/test_tach_avg_seq.sv
module test_tach_avg_seq;
    localparam int TICK = 100;
    localparam int NCH  = 16;
    localparam int W    = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NCH-1:0]   chan_present;
    logic [NCH-1:0]   cap_valid;
    logic [NCH*W-1:0] cap_value;
    logic [NCH-1:0]   tmo_valid;
    logic [NCH-1:0]   run_en;
    logic [NCH-1:0]   reload;
    logic [NCH*W-1:0] avg_count;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;
    logic [NCH-1:0] exp_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tach_avg_seq #(.TICK_CYCLES(TICK)) i_tach_avg_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .chan_present (chan_present),
        .cap_valid    (cap_valid),
        .cap_value    (cap_value),
        .tmo_valid    (tmo_valid),
        .run_en       (run_en),
        .reload       (reload),
        .avg_count    (avg_count)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] avg_of(input int ch);
        return avg_count[ch*W +: W];
    endfunction

    function automatic logic [W-1:0] el(input logic [W-1:0] d);
        return 16'hFFFF - d;
    endfunction

    task automatic cap(input int ch, input logic [W-1:0] v);
        @(negedge clk);
        cap_valid[ch] = 1'b1;
        cap_value[ch*W +: W] = v;
        @(negedge clk);
        cap_valid[ch] = 1'b0;
    endtask

    task automatic tmo(input int ch);
        @(negedge clk);
        tmo_valid[ch] = 1'b1;
        @(negedge clk);
        tmo_valid[ch] = 1'b0;
    endtask

    task automatic cap_and_tmo(input int ch, input logic [W-1:0] v);
        @(negedge clk);
        cap_valid[ch] = 1'b1;
        tmo_valid[ch] = 1'b1;
        cap_value[ch*W +: W] = v;
        @(negedge clk);
        cap_valid[ch] = 1'b0;
        tmo_valid[ch] = 1'b0;
    endtask

    task automatic wait_reload(input logic [NCH-1:0] m);
        do @(negedge clk); while ((reload & m) != m);
    endtask

    // monitor: pops expected restart masks and checks order and spacing (R2)
    initial begin
        int last = -1;
        forever begin
            @(negedge clk);
            if (rst_n === 1'b1 && reload != '0 && exp_q.size() > 0) begin
                logic [NCH-1:0] e;
                e = exp_q.pop_front();
                chk(reload == e, "R2 restart group mask", 32'(reload), 32'(e));
                if (last >= 0)
                    chk(cyc - last == TICK, "R2 tick spacing", 32'(cyc - last), 32'(TICK));
                last = cyc;
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        chan_present = 16'hF7FF;            // channel 11 absent
        cap_valid = '0;
        tmo_valid = '0;
        cap_value = '0;
        // expected restart masks: groups 0,1,2,3,0,1
        exp_q.push_back(16'h0303);
        exp_q.push_back(16'h040C);
        exp_q.push_back(16'h3030);
        exp_q.push_back(16'hC0C0);
        exp_q.push_back(16'h0303);
        exp_q.push_back(16'h040C);
        repeat (3) @(negedge clk);
        chk(run_en == '0, "R1 run_en reset", 32'(run_en), 0);
        chk(reload == '0, "R1 reload reset", 32'(reload), 0);
        chk(avg_count == '0, "R1 avg reset", avg_count[31:0], 0);
        rst_n = 1'b1;

        // R11: capture before any restart is ignored
        cap(0, 16'h0000);
        chk(run_en[0] == 1'b0 && avg_of(0) == 0, "R11 unarmed capture", 32'(avg_of(0)), 0);

        wait_reload(16'h0303);
        chk(run_en == 16'h0303, "R3 group 0 armed", 32'(run_en), 32'h0303);

        // R5..R7 on channel 0: deltas 100 and 300 -> 200
        cap(0, 16'h1234);
        chk(run_en[0] && avg_of(0) == 0, "R5 first capture dropped", 32'(avg_of(0)), 0);
        cap(0, el(100));
        chk(run_en[0] && avg_of(0) == 0, "R6 accumulate no output", 32'(avg_of(0)), 0);
        cap(0, el(300));
        chk(avg_of(0) == 200, "R7 average", 32'(avg_of(0)), 200);
        chk(run_en[0] == 1'b0, "R7 channel stopped", 32'(run_en[0]), 0);

        // R11: stopped channel ignores more captures and timeouts
        cap(0, el(5000)); cap(0, el(5000)); cap(0, el(5000)); tmo(0);
        chk(avg_of(0) == 200, "R11 stopped channel holds", 32'(avg_of(0)), 200);

        // R7 truncation: deltas 10 and 21 -> 15
        cap(1, 16'h0); cap(1, el(10)); cap(1, el(21));
        chk(avg_of(1) == 15, "R7 truncated average", 32'(avg_of(1)), 15);

        // R9: timeout with capture in FIRST
        cap(8, 16'h0);
        cap_and_tmo(8, el(900));
        chk(run_en[8] == 1'b0 && avg_of(8) == 0, "R9 timeout wins", 32'({run_en[8], avg_of(8)}), 0);
        cap(8, el(900)); cap(8, el(900));
        chk(avg_of(8) == 0, "R11 after timeout ignored", 32'(avg_of(8)), 0);

        // prepare channel 9 in ENOUGH for the restart collision
        cap(9, 16'h0); cap(9, el(40));

        wait_reload(16'h040C);
        chk(run_en[11] == 1'b0 && reload[11] == 1'b0, "R4 absent not armed", 32'(run_en[11]), 0);
        chk(run_en[10] == 1'b1, "R3 group 1 armed", 32'(run_en[10]), 1);
        cap(11, 16'h0); cap(11, el(7)); cap(11, el(9));
        chk(avg_of(11) == 0 && run_en[11] == 1'b0, "R4 absent ignores captures", 32'(avg_of(11)), 0);

        // R6 width: two full-range deltas -> 0xFFFF
        cap(10, 16'h5); cap(10, 16'h0); cap(10, 16'h0);
        chk(avg_of(10) == 16'hFFFF, "R6 full-range accumulate", 32'(avg_of(10)), 32'hFFFF);

        // R10: capture lands on the restart edge of group 0
        wait_reload(16'hC0C0);
        repeat (TICK - 1) @(negedge clk);
        cap_valid[9] = 1'b1;
        cap_value[9*W +: W] = el(1000);
        @(negedge clk);
        cap_valid[9] = 1'b0;
        chk(run_en[9] == 1'b1 && reload[9] == 1'b1, "R10 restart wins", 32'({reload[9], run_en[9]}), 3);
        chk(avg_of(9) == 0, "R10 colliding capture dropped", 32'(avg_of(9)), 0);
        cap(9, 16'h0); cap(9, el(50)); cap(9, el(70));
        chk(avg_of(9) == 60, "R3 fresh average after restart", 32'(avg_of(9)), 60);

        // R3 result held across restart, then R8 timeout zeroes it
        chk(run_en[1] == 1'b1 && avg_of(1) == 15, "R3 rearmed keeps result", 32'(avg_of(1)), 15);
        tmo(1);
        chk(run_en[1] == 1'b0 && avg_of(1) == 0, "R8 timeout zeroes", 32'({run_en[1], avg_of(1)}), 0);
        chk(avg_of(0) == 200, "R3 channel 0 result held", 32'(avg_of(0)), 200);

        wait_reload(16'h040C);
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all groups seen", 32'(exp_q.size()), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule